// File: doc/BRIEF.md
# UART Interrupt and DMA Request Generator

This block sits between the serial shifters of a UART and the software-visible side of the port. It turns per-frame events into interrupt and DMA requests. A single-cycle frame-done pulse from the receive shifter carries the byte and its line-error tags, which are frame, parity and break. A load pulse from the transmit shifter says it has taken the next byte. The block keeps a receive queue in which each byte travels together with its own error tags. It also tracks how full the transmit queue is, and it keeps an eight-flag status word that software reads to find out why a request was raised.

Each direction can route its request either to an interrupt line or to a DMA request line. In queued mode, the receive request compares the fill level with a selectable trigger level, and so does the transmit request. In this mode, a line error stays with its byte and is reported only when that byte becomes the oldest one held. In single-byte mode, the receive and transmit queues behave as one-entry holding registers and every error is reported at once. Overrun and receive time-out are always reported at once, in either mode. The error flags are sticky and clear when the status word is read.

Top module: `uart_req_gen`

## Requirements
- R1: After a synchronous active-low reset, the receive level is 0. The status word reads 0x06, which means only the transmit-queue-empty flag and the transmitter-idle flag are set. `irq_rx`, `irq_err` and `dma_rx_req` are low.
- R2: The receive queue holds up to DEPTH entries (16 by default). Bytes leave it in arrival order. `rx_head` shows the oldest byte and `rx_head_tags` shows its tags, with bit0 = parity, bit1 = frame and bit2 = break. `rx_pop` removes the oldest entry.
- R3: A frame that completes while the receive queue is full is discarded, and the overrun flag (status bit3) is set on the next edge. In queued mode the queue is full at DEPTH entries. In single-byte mode it is full at 1 entry.
- R4: In queued mode the receive condition is level >= T. The code on `cfg_rx_trig` selects T: 0 gives 1, 1 gives DEPTH/4, 2 gives DEPTH/2 and 3 gives 3*DEPTH/4. In single-byte mode the receive condition is level != 0.
- R5: In queued mode the transmit condition is transmit level <= T, with T decoded from `cfg_tx_trig` in the same way. In single-byte mode the condition is transmit level == 0. `tx_push` raises the transmit level unless the queue is full. `tx_load` lowers it unless it is 0. A push into a full queue has no effect.
- R6: When a direction's mode bit is 0, its condition drives its interrupt line. When the mode bit is 1, the condition drives its DMA request line instead. The request falls as soon as the condition goes away.
- R7: In queued mode, a tagged byte sets its parity, frame or break flag (status bits 4, 5, 6) only after it has become the oldest entry. The flag appears on the second edge after the byte becomes oldest. The tags of bytes further back have no effect.
- R8: In single-byte mode, the error inputs of a frame set their flags on the edge that accepts the frame-done pulse. In both modes, the `rx_timeout` pulse sets status bit7 on the next edge.
- R9: `irq_err` is high exactly when `cfg_err_ie` is 1 and at least one of the overrun, parity, frame, break and time-out flags is set.
- R10: A `stat_rd` pulse clears status bits 3 to 7 on the next edge. If a new error arrives in the same cycle as the read, the flag for that error stays set. Bits 0 to 2 are not affected by the read.
- R11: Status bit0 is set when the receive level is not 0. Bit1 is set when the transmit level is 0. Bit2 is set when the transmit level is 0 and no frame is in flight. A frame is in flight from an accepted `tx_load` until `tx_done`.
- R12: An `rx_pop` while the receive queue is empty is ignored, and later writes and reads keep their order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_fifo_en | input | 1 | 1 = queued mode, 0 = single-byte mode |
| cfg_rx_dma | input | 1 | Receive request routing: 0 interrupt, 1 DMA |
| cfg_tx_dma | input | 1 | Transmit request routing: 0 interrupt, 1 DMA |
| cfg_err_ie | input | 1 | Error interrupt enable |
| cfg_rx_trig | input | 2 | Receive trigger level code |
| cfg_tx_trig | input | 2 | Transmit trigger level code |
| rx_done | input | 1 | Receive frame complete pulse |
| rx_byte | input | DW (8) | Received byte |
| rx_frm_err | input | 1 | Frame error on this frame |
| rx_par_err | input | 1 | Parity error on this frame |
| rx_brk | input | 1 | Break detected on this frame |
| rx_timeout | input | 1 | Receive time-out pulse |
| rx_pop | input | 1 | Remove the oldest receive entry |
| tx_push | input | 1 | A byte is written into the transmit queue |
| tx_load | input | 1 | The transmit shifter takes a byte |
| tx_done | input | 1 | The transmit shifter has finished its frame |
| stat_rd | input | 1 | Status read strobe; clears the error flags |
| status | output | 8 | Flags: 0 rx ready, 1 tx queue empty, 2 tx idle, 3 overrun, 4 parity, 5 frame, 6 break, 7 time-out |
| rx_head | output | DW (8) | Oldest received byte |
| rx_head_tags | output | 3 | Tags of the oldest byte |
| rx_level | output | clog2(DEPTH+1) (5) | Receive queue fill level |
| irq_rx | output | 1 | Receive interrupt request |
| irq_tx | output | 1 | Transmit interrupt request |
| irq_err | output | 1 | Receive status interrupt request |
| dma_rx_req | output | 1 | Receive DMA request |
| dma_tx_req | output | 1 | Transmit DMA request |

## Verification
The bench builds the block with its defaults: DEPTH 16 and 8-bit data. This makes the trigger levels 1, 4, 8 and 12, so the bench can fill both queues to their limit and walk every trigger threshold. It can also push one entry past full to show the overrun discard and the ignored transmit write. With this small depth, the bench can drain the receive queue entry by entry and confirm the order, and it can follow a tagged byte as it moves from behind the head up to the head.

// File: rtl/uirq_pkg.sv
// Package: shared tag type, status bit positions and the trigger level decode.
// Assumes the queue depth is a power of two and at least 4.
package uirq_pkg;

    // Per-byte line error tags, bit0 parity, bit1 frame, bit2 break
    typedef struct packed {
        logic brk;
        logic frm;
        logic par;
    } rx_tags_t;

    localparam int TAG_W = 3;

    // Status word bit positions
    localparam int ST_RX_RDY   = 0;
    localparam int ST_TX_EMPTY = 1;
    localparam int ST_TX_IDLE  = 2;
    localparam int ST_OVR      = 3;
    localparam int ST_PAR      = 4;
    localparam int ST_FRM      = 5;
    localparam int ST_BRK      = 6;
    localparam int ST_TMO      = 7;

    // Trigger level from its 2-bit code, scaled by the queue depth
    function automatic int trig_level(input logic [1:0] code, input int depth);
        case (code)
            2'd0:    return 1;
            2'd1:    return depth / 4;
            2'd2:    return depth / 2;
            default: return (3 * depth) / 4;
        endcase
    endfunction

endpackage

// File: rtl/uirq_rx_fifo.sv
// Receive queue: stores each byte with its error tags and presents the oldest entry.
// In single-byte mode the usable capacity is one entry. head_fresh pulses for one
// cycle after a new entry becomes the oldest one.
// Assumes DEPTH is a power of two so the pointers wrap naturally.
module uirq_rx_fifo #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    parameter int TW    = 3,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic [TW-1:0] wtags,
    input  logic          rd,
    output logic          full,
    output logic [LW-1:0] level,
    output logic [DW-1:0] head_data,
    output logic [TW-1:0] head_tags,
    output logic          head_fresh
);
    localparam int EW = DW + TW;

    logic [EW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [LW-1:0] cap, level_nxt;
    logic          do_wr, do_rd, arrive;

    // Capacity depends on the mode; full compares against it
    always_comb begin
        cap       = fifo_en ? LW'(DEPTH) : LW'(1);
        full      = (level >= cap);
        do_wr     = wr && !full;
        do_rd     = rd && (level != '0);
        level_nxt = level + LW'(do_wr) - LW'(do_rd);
        arrive    = (do_rd && (level_nxt != '0)) || (do_wr && (level == '0));
    end

    // Entry storage, written without reset
    always_ff @(posedge clk) begin
        if (do_wr) mem[wptr] <= {wtags, wdata};
    end

    // Pointers, fill level and the head-arrival marker
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr       <= '0;
            rptr       <= '0;
            level      <= '0;
            head_fresh <= 1'b0;
        end else begin
            if (do_wr) wptr <= wptr + 1'b1;
            if (do_rd) rptr <= rptr + 1'b1;
            level      <= level_nxt;
            head_fresh <= arrive;
        end
    end

    // Oldest entry, zero while empty
    always_comb begin
        if (level != '0) {head_tags, head_data} = mem[rptr];
        else             {head_tags, head_data} = '0;
    end

    // R2
    rx_level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));
    // R3
    rx_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && full && !rd) |=> $stable(level));
    // R12
    rx_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !wr && level == '0) |=> level == '0);

endmodule

// File: rtl/uirq_tx_track.sv
// Transmit side tracker: counts the bytes waiting in the transmit queue and whether
// the shifter has a frame in flight. In single-byte mode the capacity is one.
// Assumes tx_load and tx_done come from the shifter as single-cycle pulses.
module uirq_tx_track #(
    parameter int DEPTH = 16,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic          push,
    input  logic          load,
    input  logic          done,
    output logic [LW-1:0] level,
    output logic          busy
);
    logic [LW-1:0] cap;
    logic          do_push, do_load;

    // Accept pushes below capacity and loads only when something is queued
    always_comb begin
        cap     = fifo_en ? LW'(DEPTH) : LW'(1);
        do_push = push && (level < cap);
        do_load = load && (level != '0);
    end

    // Level counter and in-flight flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= '0;
            busy  <= 1'b0;
        end else begin
            level <= level + LW'(do_push) - LW'(do_load);
            if (do_load)   busy <= 1'b1;
            else if (done) busy <= 1'b0;
        end
    end

    // R5
    tx_level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));
    // R5
    tx_full_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !load && level >= cap) |=> $stable(level));
    // R11
    tx_busy_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && level != '0) |=> busy);

endmodule

// File: rtl/uirq_req_gen.sv
// One direction's request logic: compares the fill level with the decoded trigger
// level and routes the result to the interrupt line or to the DMA request line.
// IS_RX selects the comparison sense: receive fires at or above, transmit at or below.
module uirq_req_gen #(
    parameter int DEPTH = 16,
    parameter bit IS_RX = 1'b1,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          fifo_en,
    input  logic          dma_mode,
    input  logic [1:0]    trig_code,
    input  logic [LW-1:0] level,
    output logic          irq,
    output logic          dma
);
    logic [LW-1:0] trig;
    logic          cond;

    // Decoded trigger level
    always_comb trig = LW'(uirq_pkg::trig_level(trig_code, DEPTH));

    // Condition by direction
    generate
        if (IS_RX) begin : g_rx
            always_comb cond = fifo_en ? (level >= trig) : (level != '0);
        end else begin : g_tx
            always_comb cond = fifo_en ? (level <= trig) : (level == '0);
        end
    endgenerate

    // Routing by mode
    always_comb begin
        irq = cond && !dma_mode;
        dma = cond && dma_mode;
    end

endmodule

// File: rtl/uirq_status.sv
// Sticky error flags with clear-on-read. Queued-mode line errors come from the head
// entry when it becomes the oldest; single-byte mode line errors, overrun and time-out
// come straight from the frame event. A set in the read cycle wins over the clear.
module uirq_status (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fifo_en,
    input  logic                rx_done,
    input  uirq_pkg::rx_tags_t  rx_tags,
    input  logic                rx_full,
    input  logic                rx_timeout,
    input  logic                head_fresh,
    input  uirq_pkg::rx_tags_t  head_tags,
    input  logic                stat_rd,
    input  logic                err_ie,
    output logic                f_ovr,
    output logic                f_par,
    output logic                f_frm,
    output logic                f_brk,
    output logic                f_tmo,
    output logic                irq_err
);
    logic s_ovr, s_par, s_frm, s_brk, s_tmo, now_line, head_line;

    // Set terms from the two error paths
    always_comb begin
        now_line  = !fifo_en && rx_done;
        head_line = fifo_en && head_fresh;
        s_ovr = rx_done && rx_full;
        s_par = (now_line && rx_tags.par) || (head_line && head_tags.par);
        s_frm = (now_line && rx_tags.frm) || (head_line && head_tags.frm);
        s_brk = (now_line && rx_tags.brk) || (head_line && head_tags.brk);
        s_tmo = rx_timeout;
    end

    // Sticky flags: set, or hold unless read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {f_ovr, f_par, f_frm, f_brk, f_tmo} <= '0;
        end else begin
            f_ovr <= s_ovr || (f_ovr && !stat_rd);
            f_par <= s_par || (f_par && !stat_rd);
            f_frm <= s_frm || (f_frm && !stat_rd);
            f_brk <= s_brk || (f_brk && !stat_rd);
            f_tmo <= s_tmo || (f_tmo && !stat_rd);
        end
    end

    // Error interrupt
    always_comb irq_err = err_ie && (f_ovr || f_par || f_frm || f_brk || f_tmo);

    // R3
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && rx_full) |=> f_ovr);
    // R8
    tmo_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_timeout |=> f_tmo);
    // R10
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !rx_done && !rx_timeout && !head_fresh) |=>
        !(f_ovr || f_par || f_frm || f_brk || f_tmo));

endmodule

// File: rtl/uart_req_gen.sv
// Top: UART interrupt and DMA request generator. Wires the receive queue, the
// transmit tracker, one request generator per direction and the status flags, and
// assembles the eight-bit status word.
// Assumes all event inputs are single-cycle pulses synchronous to clk.
module uart_req_gen #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_fifo_en,
    input  logic          cfg_rx_dma,
    input  logic          cfg_tx_dma,
    input  logic          cfg_err_ie,
    input  logic [1:0]    cfg_rx_trig,
    input  logic [1:0]    cfg_tx_trig,
    input  logic          rx_done,
    input  logic [DW-1:0] rx_byte,
    input  logic          rx_frm_err,
    input  logic          rx_par_err,
    input  logic          rx_brk,
    input  logic          rx_timeout,
    input  logic          rx_pop,
    input  logic          tx_push,
    input  logic          tx_load,
    input  logic          tx_done,
    input  logic          stat_rd,
    output logic [7:0]    status,
    output logic [DW-1:0] rx_head,
    output logic [2:0]    rx_head_tags,
    output logic [LW-1:0] rx_level,
    output logic          irq_rx,
    output logic          irq_tx,
    output logic          irq_err,
    output logic          dma_rx_req,
    output logic          dma_tx_req
);
    import uirq_pkg::*;

    rx_tags_t      in_tags, hd_tags;
    logic          rx_full, head_fresh, tx_busy;
    logic [LW-1:0] tx_level;
    logic          f_ovr, f_par, f_frm, f_brk, f_tmo;

    // Pack the incoming error flags as tags
    always_comb begin
        in_tags.par  = rx_par_err;
        in_tags.frm  = rx_frm_err;
        in_tags.brk  = rx_brk;
        rx_head_tags = hd_tags;
    end

    uirq_rx_fifo #(.DEPTH(DEPTH), .DW(DW), .TW(TAG_W)) u_rx_fifo (
        .clk(clk), .rst_n(rst_n), .fifo_en(cfg_fifo_en),
        .wr(rx_done), .wdata(rx_byte), .wtags(in_tags), .rd(rx_pop),
        .full(rx_full), .level(rx_level), .head_data(rx_head),
        .head_tags(hd_tags), .head_fresh(head_fresh)
    );

    uirq_tx_track #(.DEPTH(DEPTH)) u_tx_track (
        .clk(clk), .rst_n(rst_n), .fifo_en(cfg_fifo_en),
        .push(tx_push), .load(tx_load), .done(tx_done),
        .level(tx_level), .busy(tx_busy)
    );

    uirq_req_gen #(.DEPTH(DEPTH), .IS_RX(1'b1)) u_rx_req (
        .fifo_en(cfg_fifo_en), .dma_mode(cfg_rx_dma), .trig_code(cfg_rx_trig),
        .level(rx_level), .irq(irq_rx), .dma(dma_rx_req)
    );

    uirq_req_gen #(.DEPTH(DEPTH), .IS_RX(1'b0)) u_tx_req (
        .fifo_en(cfg_fifo_en), .dma_mode(cfg_tx_dma), .trig_code(cfg_tx_trig),
        .level(tx_level), .irq(irq_tx), .dma(dma_tx_req)
    );

    uirq_status u_status (
        .clk(clk), .rst_n(rst_n), .fifo_en(cfg_fifo_en),
        .rx_done(rx_done), .rx_tags(in_tags), .rx_full(rx_full),
        .rx_timeout(rx_timeout), .head_fresh(head_fresh), .head_tags(hd_tags),
        .stat_rd(stat_rd), .err_ie(cfg_err_ie),
        .f_ovr(f_ovr), .f_par(f_par), .f_frm(f_frm), .f_brk(f_brk),
        .f_tmo(f_tmo), .irq_err(irq_err)
    );

    // Status word assembly
    always_comb begin
        status              = '0;
        status[ST_RX_RDY]   = (rx_level != '0);
        status[ST_TX_EMPTY] = (tx_level == '0);
        status[ST_TX_IDLE]  = (tx_level == '0) && !tx_busy;
        status[ST_OVR]      = f_ovr;
        status[ST_PAR]      = f_par;
        status[ST_FRM]      = f_frm;
        status[ST_BRK]      = f_brk;
        status[ST_TMO]      = f_tmo;
    end

    // R6
    rx_route_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_rx && dma_rx_req) && !(irq_tx && dma_tx_req));
    // R9
    err_irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err |-> (cfg_err_ie && $countones(status[7:3]) != 0));
    // R7
    head_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_fifo_en && head_fresh && hd_tags.par) |=> status[ST_PAR]);

endmodule

// File: tb/test_uart_req_gen.sv
`timescale 1ns/1ps
module test_uart_req_gen;
    localparam int DEPTH = 16;
    localparam int LW = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_fifo_en = 1'b1, cfg_rx_dma = 1'b0, cfg_tx_dma = 1'b0, cfg_err_ie = 1'b0;
    logic [1:0] cfg_rx_trig = 2'd0, cfg_tx_trig = 2'd0;
    logic rx_done = 1'b0, rx_frm_err = 1'b0, rx_par_err = 1'b0, rx_brk = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic rx_timeout = 1'b0, rx_pop = 1'b0, tx_push = 1'b0, tx_load = 1'b0;
    logic tx_done = 1'b0, stat_rd = 1'b0;
    logic [7:0] status, rx_head;
    logic [2:0] rx_head_tags;
    logic [LW-1:0] rx_level;
    logic irq_rx, irq_tx, irq_err, dma_rx_req, dma_tx_req;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    uart_req_gen #(.DEPTH(DEPTH), .DW(8)) i_uart_req_gen (
        .clk(clk), .rst_n(rst_n), .cfg_fifo_en(cfg_fifo_en), .cfg_rx_dma(cfg_rx_dma),
        .cfg_tx_dma(cfg_tx_dma), .cfg_err_ie(cfg_err_ie), .cfg_rx_trig(cfg_rx_trig),
        .cfg_tx_trig(cfg_tx_trig), .rx_done(rx_done), .rx_byte(rx_byte),
        .rx_frm_err(rx_frm_err), .rx_par_err(rx_par_err), .rx_brk(rx_brk),
        .rx_timeout(rx_timeout), .rx_pop(rx_pop), .tx_push(tx_push), .tx_load(tx_load),
        .tx_done(tx_done), .stat_rd(stat_rd), .status(status), .rx_head(rx_head),
        .rx_head_tags(rx_head_tags), .rx_level(rx_level), .irq_rx(irq_rx),
        .irq_tx(irq_tx), .irq_err(irq_err), .dma_rx_req(dma_rx_req),
        .dma_tx_req(dma_tx_req)
    );

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic rx_frame(input logic [7:0] b, input logic [2:0] tags);
        rx_done = 1'b1; rx_byte = b;
        {rx_brk, rx_frm_err, rx_par_err} = tags;
        tick();
        rx_done = 1'b0; {rx_brk, rx_frm_err, rx_par_err} = 3'b000;
    endtask

    task automatic pop();
        rx_pop = 1'b1; tick(); rx_pop = 1'b0;
    endtask

    task automatic rd_status();
        stat_rd = 1'b1; tick(); stat_rd = 1'b0;
    endtask

    task automatic push_tx();
        tx_push = 1'b1; tick(); tx_push = 1'b0;
    endtask

    task automatic load_tx();
        tx_load = 1'b1; tick(); tx_load = 1'b0;
    endtask

    function automatic int trig_of(input int code);
        case (code)
            0: return 1;
            1: return DEPTH / 4;
            2: return DEPTH / 2;
            default: return (3 * DEPTH) / 4;
        endcase
    endfunction

    task automatic t_reset();
        check("R1 status", status, 8'h06);
        check("R1 level", rx_level, 0);
        check("R1 irq_rx", irq_rx, 0);
        check("R1 irq_err", irq_err, 0);
        check("R1 dma_rx", dma_rx_req, 0);
    endtask

    task automatic t_order_and_deferred();
        cfg_fifo_en = 1'b1; cfg_rx_trig = 2'd0; cfg_err_ie = 1'b1;
        rx_frame(8'hA5, 3'b000);
        rx_frame(8'h3C, 3'b001);
        rx_frame(8'h71, 3'b000);
        tick();
        check("R2 level", rx_level, 3);
        check("R2 head", rx_head, 8'hA5);
        check("R7 not at head yet", status[4], 0);
        pop();
        check("R2 head tags", rx_head_tags, 3'b001);
        check("R7 flag not before second edge", status[4], 0);
        tick();
        check("R7 parity at head", status[4], 1);
        check("R9 irq_err", irq_err, 1);
        rd_status();
        check("R10 cleared", status[7:3], 0);
        check("R10 rx ready kept", status[0], 1);
        pop();
        check("R2 third head", rx_head, 8'h71);
        pop();
        check("R11 rx ready empty", status[0], 0);
    endtask

    task automatic t_rx_trigger();
        cfg_fifo_en = 1'b1; cfg_err_ie = 1'b1;
        for (int c = 0; c < 4; c++) begin
            cfg_rx_trig = c[1:0];
            for (int i = 0; i < DEPTH; i++) begin
                rx_frame(8'(i), 3'b000);
                check($sformatf("R4 code%0d lvl%0d", c, i + 1), irq_rx,
                      int'((i + 1) >= trig_of(c)));
            end
            if (c == 3) begin
                rx_frame(8'hEE, 3'b000);
                check("R3 level held", rx_level, DEPTH);
                check("R3 overrun", status[3], 1);
                check("R9 overrun irq", irq_err, 1);
                rd_status();
            end
            for (int i = 0; i < DEPTH; i++) begin
                check("R2 drain order", rx_head, i);
                pop();
            end
            check("R2 drained", rx_level, 0);
        end
    endtask

    task automatic t_tx_trigger();
        cfg_fifo_en = 1'b1; cfg_tx_trig = 2'd1;
        check("R5 empty cond", irq_tx, 1);
        for (int i = 1; i <= DEPTH; i++) begin
            push_tx();
            check($sformatf("R5 push lvl%0d", i), irq_tx, int'(i <= DEPTH / 4));
        end
        push_tx();
        for (int i = 1; i <= DEPTH; i++) begin
            load_tx();
            check($sformatf("R5 load lvl%0d", DEPTH - i), irq_tx, int'((DEPTH - i) <= DEPTH / 4));
        end
        check("R5 full push ignored", status[1], 1);
        check("R11 in flight", status[2], 0);
        tx_done = 1'b1; tick(); tx_done = 1'b0;
        check("R11 idle", status[2], 1);
        cfg_tx_trig = 2'd0;
    endtask

    task automatic t_dma();
        cfg_fifo_en = 1'b1; cfg_rx_dma = 1'b1; cfg_rx_trig = 2'd0;
        rx_frame(8'h11, 3'b000);
        check("R6 dma_rx", dma_rx_req, 1);
        check("R6 irq_rx off", irq_rx, 0);
        pop();
        check("R6 dma_rx drop", dma_rx_req, 0);
        cfg_tx_dma = 1'b1; tick();
        check("R6 dma_tx", dma_tx_req, 1);
        check("R6 irq_tx off", irq_tx, 0);
        push_tx(); push_tx();
        check("R6 dma_tx drop", dma_tx_req, 0);
        load_tx(); load_tx();
        tx_done = 1'b1; tick(); tx_done = 1'b0;
        cfg_rx_dma = 1'b0; cfg_tx_dma = 1'b0;
    endtask

    task automatic t_single_byte();
        cfg_fifo_en = 1'b0; cfg_err_ie = 1'b0;
        rd_status();
        rx_frame(8'h5A, 3'b010);
        check("R8 frame immediate", status[5], 1);
        check("R4 single irq_rx", irq_rx, 1);
        check("R9 disabled", irq_err, 0);
        rx_frame(8'h66, 3'b000);
        check("R3 single overrun", status[3], 1);
        check("R3 head kept", rx_head, 8'h5A);
        check("R3 single level", rx_level, 1);
        cfg_err_ie = 1'b1; #1;
        check("R9 enabled", irq_err, 1);
        pop();
        rx_timeout = 1'b1; tick(); rx_timeout = 1'b0;
        check("R8 timeout", status[7], 1);
        push_tx();
        check("R5 single held", irq_tx, 0);
        push_tx();
        load_tx();
        check("R5 single second push ignored", irq_tx, 1);
        tx_done = 1'b1; tick(); tx_done = 1'b0;
        rd_status();
    endtask

    task automatic t_read_collision();
        cfg_fifo_en = 1'b1;
        stat_rd = 1'b1; rx_timeout = 1'b1; tick();
        stat_rd = 1'b0; rx_timeout = 1'b0;
        check("R10 set wins", status[7], 1);
        rd_status();
        check("R10 clear", status[7], 0);
    endtask

    task automatic t_pop_empty();
        cfg_fifo_en = 1'b1;
        pop();
        check("R12 level", rx_level, 0);
        check("R12 ready", status[0], 0);
        rx_frame(8'h9D, 3'b000);
        check("R12 head after", rx_head, 8'h9D);
        check("R12 level after", rx_level, 1);
        pop();
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_order_and_deferred();
        t_rx_trigger();
        t_tx_trigger();
        t_dma();
        t_single_byte();
        t_read_collision();
        t_pop_empty();
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule